// File: doc/BRIEF.md
# Interrupt Enable Unit with Prior-State Reporting

This block holds the interrupt-enable flag, the carry flag and the zero flag of a small 8-bit controller core. It runs the instructions that enable or disable interrupts. Each of these instructions also writes carry with the enable state that held just before it ran. Software can therefore disable interrupts around a critical section, then leave the section with a return that is taken only on no-carry, followed by an enable. Nested sections that run with interrupts already off then never turn them back on by mistake.

The unit also decides when to take an interrupt. A request is taken at an instruction boundary, when the enable flag is set and an instruction slot is offered. Taking it copies carry and zero into shadow flags, clears the enable flag and pulses an acknowledge. A return-from-interrupt restores both flags from the shadows and sets the enable flag from an operand bit. An optional build mode adds an instruction that copies carry into the enable flag. With it, a saved state can be restored in one instruction.

Top module: `ieu_top`

## Requirements
- R1: While reset is asserted, and until the first instruction after reset, ie, carry, zero and irq_ack read 0. The shadow flags are also 0, so a return-from-interrupt issued straight after reset loads carry=0 and zero=0.
- R2: A disable instruction (instr_op=2, instr_arg=0) that is executed clears ie and sets carry to the value ie had before it, both visible after the next rising clock edge.
- R3: An enable instruction (instr_op=2, instr_arg=1) that is executed sets ie and sets carry to the value ie had before it.
- R4: The enable and disable instructions leave zero unchanged. Software still treats zero as undefined after them.
- R5: An executed flag-update instruction (instr_op=1) loads carry from alu_carry and zero from alu_zero, and leaves ie unchanged. Opcodes 0 and 5 to 7 change no flag.
- R6: With IE_FROM_C_EN=1, an executed instr_op=4 loads ie with the current carry and leaves carry and zero unchanged. With IE_FROM_C_EN=0 the same opcode changes no flag.
- R7: When instr_valid=1, ie=1 and irq=1 in the same cycle, the interrupt is taken. The offered instruction is not executed, carry and zero are copied into the shadow flags, and ie is cleared. irq_ack is 1 for exactly the one following cycle.
- R8: No interrupt is taken while ie=0 or instr_valid=0. A request held high stays pending and is taken at the first slot where both are 1.
- R9: An executed return-from-interrupt (instr_op=3) loads carry and zero from the shadow flags and sets ie to instr_arg.
- R10: No interrupt is taken in the cycle right after an executed disable instruction, whatever the state of irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | An instruction slot is offered in this cycle |
| instr_op | input | 3 | Decoded instruction class: 0 none, 1 flag update, 2 enable/disable, 3 return-from-interrupt, 4 enable-from-carry |
| instr_arg | input | 1 | Operand bit: 1 selects enable (op 2) or ie after return (op 3) |
| alu_carry | input | 1 | Carry result of the datapath for op 1 |
| alu_zero | input | 1 | Zero result of the datapath for op 1 |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_ack | output | 1 | One-cycle pulse after an interrupt is taken |
| ie | output | 1 | Interrupt-enable flag |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |

## Verification
The bench builds two copies side by side: one with IE_FROM_C_EN=1 and one with IE_FROM_C_EN=0, both with a two-stage reset synchronizer. Both copies get the same stimulus, so one run shows the enable-from-carry opcode restoring ie in one copy and doing nothing in the other. A directed part covers nested disable sequences, a request held high across disabled stretches and empty slots, and preemption of the offered instruction. A random part then mixes every opcode with the request line.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_FLAGS    = 3'd1,
    OP_INTCTL   = 3'd2,
    OP_RETI     = 3'd3,
    OP_IE_FROMC = 3'd4
  } ieu_op_e;
endpackage

// File: rtl/ieu_rst_sync.sv
module ieu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ieu_entry.sv
module ieu_entry (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_valid,
  input  logic ie_q,
  input  logic irq,
  output logic take,
  output logic ack_q
);
  logic ack_d;

  always_comb begin
    take  = slot_valid & ie_q & irq;
    ack_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end
endmodule

// File: rtl/ieu_enable.sv
module ieu_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic do_ctl,
  input  logic do_reti,
  input  logic do_iec,
  input  logic arg,
  input  logic carry_q,
  output logic ie_q
);
  logic ie_d;
  logic ie_en;

  always_comb begin
    ie_en = take | do_ctl | do_reti | do_iec;
    if (take)                   ie_d = 1'b0;
    else if (do_ctl || do_reti) ie_d = arg;
    else if (do_iec)            ie_d = carry_q;
    else                        ie_d = ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end
endmodule

// File: rtl/ieu_flags.sv
module ieu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic do_flags,
  input  logic do_ctl,
  input  logic do_reti,
  input  logic ie_prev,
  input  logic alu_carry,
  input  logic alu_zero,
  output logic carry_q,
  output logic zero_q
);
  logic shc_q, shz_q;
  logic carry_d, zero_d;
  logic c_en, z_en;

  // carry source: prior enable state for the enable/disable class,
  // shadow on return, datapath otherwise
  always_comb begin
    c_en = do_flags | do_ctl | do_reti;
    z_en = do_flags | do_reti;
    if (do_ctl)       carry_d = ie_prev;
    else if (do_reti) carry_d = shc_q;
    else              carry_d = alu_carry;
    zero_d = do_reti ? shz_q : alu_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (c_en) carry_q <= carry_d;
      if (z_en) zero_q  <= zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shc_q <= 1'b0;
      shz_q <= 1'b0;
    end else if (take) begin
      shc_q <= carry_q;
      shz_q <= zero_q;
    end
  end
endmodule

// File: rtl/ieu_top.sv
module ieu_top
  import ieu_pkg::*;
#(
  parameter bit IE_FROM_C_EN   = 1'b1,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid,
  input  logic [2:0] instr_op,
  input  logic       instr_arg,
  input  logic       alu_carry,
  input  logic       alu_zero,
  input  logic       irq,
  output logic       irq_ack,
  output logic       ie,
  output logic       carry,
  output logic       zero
);
  logic rst_sync_n;
  logic take, exec;
  logic do_flags, do_ctl, do_reti, do_iec;
  logic ie_q, carry_q, zero_q;

  ieu_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ieu_entry u_entry (
    .clk(clk), .rst_n(rst_sync_n), .slot_valid(instr_valid),
    .ie_q(ie_q), .irq(irq), .take(take), .ack_q(irq_ack)
  );

  always_comb begin
    exec     = instr_valid & ~take;
    do_flags = exec & (instr_op == OP_FLAGS);
    do_ctl   = exec & (instr_op == OP_INTCTL);
    do_reti  = exec & (instr_op == OP_RETI);
  end

  generate
    if (IE_FROM_C_EN) begin : g_iec
      assign do_iec = exec & (instr_op == OP_IE_FROMC);
    end else begin : g_no_iec
      assign do_iec = 1'b0;
    end
  endgenerate

  ieu_enable u_enable (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .do_ctl(do_ctl),
    .do_reti(do_reti), .do_iec(do_iec), .arg(instr_arg),
    .carry_q(carry_q), .ie_q(ie_q)
  );

  ieu_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .do_flags(do_flags),
    .do_ctl(do_ctl), .do_reti(do_reti), .ie_prev(ie_q),
    .alu_carry(alu_carry), .alu_zero(alu_zero),
    .carry_q(carry_q), .zero_q(zero_q)
  );

  assign ie    = ie_q;
  assign carry = carry_q;
  assign zero  = zero_q;
endmodule

// File: rtl/ieu_checker.sv
module ieu_checker (
  input logic       clk,
  input logic       rst_ok,
  input logic       instr_valid,
  input logic [2:0] instr_op,
  input logic       instr_arg,
  input logic       irq,
  input logic       irq_ack,
  input logic       ie,
  input logic       carry,
  input logic       zero
);
  logic entry_now, di_now, ei_now;
  assign entry_now = instr_valid && ie && irq;
  assign di_now = instr_valid && (instr_op == 3'd2) && !instr_arg && !entry_now;
  assign ei_now = instr_valid && (instr_op == 3'd2) && instr_arg && !entry_now;

  // R2
  di_prev_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    di_now |=> (!ie && (carry == $past(ie))));
  // R3
  ei_prev_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ei_now |=> (ie && (carry == $past(ie))));
  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (di_now || ei_now) |=> $stable(zero));
  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_ack |=> !irq_ack);
  // R7
  entry_ack_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    entry_now |=> (irq_ack && !ie));
  // R8
  no_entry_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !entry_now |=> !irq_ack);
  // R10
  di_blocks_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    di_now |=> !entry_now);
endmodule

bind ieu_top ieu_checker u_ieu_chk (
  .clk(clk), .rst_ok(rst_sync_n), .instr_valid(instr_valid),
  .instr_op(instr_op), .instr_arg(instr_arg), .irq(irq),
  .irq_ack(irq_ack), .ie(ie), .carry(carry), .zero(zero)
);

// File: tb/ieu_top_test.sv
module ieu_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [2:0] instr_op = 3'd0;
  logic instr_arg = 1'b0;
  logic alu_carry = 1'b0;
  logic alu_zero = 1'b0;
  logic irq = 1'b0;
  logic ack_a, ie_a, c_a, z_a;
  logic ack_b, ie_b, c_b, z_b;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference state, index 0 = mode on, 1 = mode off
  bit m_ie[2], m_c[2], m_z[2], m_sc[2], m_sz[2], m_ack[2];
  int sync_cnt = 0;

  always #4 clk = ~clk;

  ieu_top #(.IE_FROM_C_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_arg(instr_arg), .alu_carry(alu_carry), .alu_zero(alu_zero),
    .irq(irq), .irq_ack(ack_a), .ie(ie_a), .carry(c_a), .zero(z_a)
  );

  ieu_top #(.IE_FROM_C_EN(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_arg(instr_arg), .alu_carry(alu_carry), .alu_zero(alu_zero),
    .irq(irq), .irq_ack(ack_b), .ie(ie_b), .carry(c_b), .zero(z_b)
  );

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n || sync_cnt < 2) begin
        m_ie[k] = 0; m_c[k] = 0; m_z[k] = 0;
        m_sc[k] = 0; m_sz[k] = 0; m_ack[k] = 0;
      end else begin
        bit old_ie;
        old_ie = m_ie[k];
        m_ack[k] = instr_valid && m_ie[k] && irq;
        if (m_ack[k]) begin
          m_sc[k] = m_c[k]; m_sz[k] = m_z[k]; m_ie[k] = 0;
        end else if (instr_valid) begin
          case (instr_op)
            3'd1: begin m_c[k] = alu_carry; m_z[k] = alu_zero; end
            3'd2: begin m_ie[k] = instr_arg; m_c[k] = old_ie; end
            3'd3: begin m_c[k] = m_sc[k]; m_z[k] = m_sz[k]; m_ie[k] = instr_arg; end
            3'd4: if (k == 0) m_ie[k] = m_c[k];
            default: ;
          endcase
        end
      end
    end
    if (!rst_n) sync_cnt = 0;
    else if (sync_cnt < 2) sync_cnt++;
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("ie",      ie_a,  m_ie[0]);
      chk("carry",   c_a,   m_c[0]);
      chk("zero",    z_a,   m_z[0]);
      chk("irq_ack", ack_a, m_ack[0]);
      chk("ie(off)",      ie_b,  m_ie[1]);
      chk("carry(off)",   c_b,   m_c[1]);
      chk("zero(off)",    z_b,   m_z[1]);
      chk("irq_ack(off)", ack_b, m_ack[1]);
    end
  end

  task automatic op(string t, logic v, logic [2:0] o, logic a, logic ac, logic az, logic rq);
    @(negedge clk);
    tag = t; instr_valid = v; instr_op = o; instr_arg = a;
    alu_carry = ac; alu_zero = az; irq = rq;
  endtask

  function automatic string tag_of(logic [2:0] o, logic rq);
    if (rq) return "R7";
    case (o)
      3'd1: return "R5";
      3'd2: return "R2";
      3'd3: return "R9";
      3'd4: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: shadows clear after reset
    op("R1", 1, 3'd3, 0, 0, 0, 0);
    // R5: flag update
    op("R5", 1, 3'd1, 0, 1, 1, 0);
    op("R5", 1, 3'd0, 0, 0, 0, 0);
    // R2/R4: disable while already disabled -> carry 0, zero held
    op("R2", 1, 3'd2, 0, 1, 0, 0);
    // R3: enable from disabled -> carry 0
    op("R3", 1, 3'd2, 1, 0, 0, 0);
    // R3: enable again -> carry 1
    op("R3", 1, 3'd2, 1, 0, 0, 0);
    // R2: nested disables -> carry 1 then 0
    op("R2", 1, 3'd2, 0, 0, 0, 0);
    op("R4", 1, 3'd2, 0, 0, 0, 0);
    // R6: enable-from-carry, carry=1 after flag update
    op("R6", 1, 3'd1, 0, 1, 0, 0);
    op("R6", 1, 3'd4, 0, 0, 0, 0);
    op("R6", 1, 3'd0, 0, 0, 0, 0);
    // R10: disable, then raise request immediately
    op("R10", 1, 3'd2, 0, 0, 0, 0);
    op("R10", 1, 3'd1, 0, 0, 1, 1);
    // R8: request pending while disabled and on empty slots
    op("R8", 1, 3'd0, 0, 0, 0, 1);
    op("R8", 1, 3'd2, 1, 0, 0, 1);
    op("R8", 0, 3'd1, 0, 1, 1, 1);
    // R7: entry preempts the offered flag update
    op("R7", 1, 3'd1, 0, 0, 0, 1);
    op("R7", 1, 3'd0, 0, 0, 0, 1);
    op("R7", 1, 3'd1, 0, 0, 0, 1);
    // R9: return re-enables, request retaken
    op("R9", 1, 3'd3, 1, 0, 0, 1);
    op("R7", 1, 3'd0, 0, 0, 0, 1);
    op("R9", 1, 3'd3, 0, 0, 0, 0);
    op("R9", 1, 3'd0, 0, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [2:0] o;
      logic rq;
      o  = 3'($urandom_range(0, 7));
      rq = ($urandom_range(0, 3) == 0);
      op(tag_of(o, rq), 1'($urandom_range(0, 4) != 0), o, 1'($urandom),
         1'($urandom), 1'($urandom), rq);
    end
    op("R8", 0, 3'd0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule